// File: doc/BRIEF.md
# Flagged Shift-Capable ALU

This block is the integer execute datapath of a 32-bit core. It combines two operands under a 3-bit operation code and produces a 32-bit result without any clock delay. It also keeps a registered set of four condition flags: zero, negative, overflow and carry. The second operand comes either from a register value or from a 16-bit constant. A small front stage widens that constant, and the way it widens depends on the operation.

The operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR and a two-way shift. For the shift, one signed amount gives both the direction and the distance. The alternate-select input has two uses. For a non-shift constant it picks which halfword the constant lands in. For any shift it picks a logical or an arithmetic shift. The flags are rewritten at a clock edge only when the flag-write enable is high. Add with carry and subtract with borrow use the carry flag as it stood before that edge.

The block has no state machine. Its only storage is the flag register, which has two behaviours: it clears on reset, and it either loads or holds at each clock edge.

Top module: `flagged_shift_alu`

## Requirements
- R1: `op_i` encodings are 000 add, 001 add-with-carry, 010 subtract, 011 subtract-with-borrow, 100 AND, 101 OR, 110 XOR, 111 shift. Add gives a+b and subtract gives a+~b+1, both modulo 2^32.
- R2: Add-with-carry gives a+b+C and subtract-with-borrow gives a+~b+C, where C is the registered carry flag before the clock edge that updates it.
- R3: AND, OR and XOR give the bitwise result of the two operands.
- R4: When `imm_sel_i`=1 and the operation is not a shift, the 16-bit constant forms the second operand. `alt_i`=1 places it in bits 31:16 and `alt_i`=0 places it in bits 15:0. The other half is 0x0000, or 0xFFFF for AND.
- R5: When `imm_sel_i`=1 and the operation is a shift, the constant is sign extended to 32 bits. For any shift, `alt_i`=0 selects a logical shift and `alt_i`=1 selects an arithmetic shift.
- R6: The shift amount is the second operand taken as a signed number. A value from 0 to 31 shifts left by that many places, and a value from -1 to -31 shifts right by its magnitude.
- R7: A shift amount whose magnitude is 32 or more gives zero for left shifts and for logical right shifts. An arithmetic right shift of that magnitude gives 32 copies of bit 31. Carry is cleared in all these cases.
- R8: After an enabled update, Z is 1 exactly when the result was zero, and N equals bit 31 of the result.
- R9: V is set for the four arithmetic operations when the two addends (a, and b or ~b) have equal sign bits that differ from the result's sign bit. V is cleared for every other operation.
- R10: C takes the carry out of bit 31 for arithmetic operations. For a left shift by 1 to 31 places it takes the last bit shifted out. A left shift by 0, right shifts and logic operations clear it.
- R11: The flags are all zero after reset, change only at a clock edge where `flag_we_i`=1, and otherwise keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Register second operand |
| imm_i | input | 16 | Constant second operand |
| imm_sel_i | input | 1 | 1 selects the widened constant as the second operand |
| alt_i | input | 1 | Halfword placement for constants, or arithmetic shift select |
| flag_we_i | input | 1 | Flag-write enable |
| result_o | output | 32 | Combinational result |
| z_o | output | 1 | Registered zero flag |
| n_o | output | 1 | Registered negative flag |
| v_o | output | 1 | Registered overflow flag |
| c_o | output | 1 | Registered carry flag |

## Verification
The bench aims at the edges of the shift range: amounts 0, 31, -31, 32, -32 and large magnitudes, in both shift types. A design that wraps the amount modulo 32 would return a shifted value where zero or sign fill is due. One that takes C from the wrong bit position would show the wrong carry after a left shift.

It also chains carry-dependent operations to show that C is taken before the update. A design that feeds back the new carry would be one off in the result. Constant tests place the value in both halves, with and without AND fill. Writes with the enable low check that the flags hold.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_ADDC  = 3'b001,
        OP_SUB   = 3'b010,
        OP_SUBB  = 3'b011,
        OP_AND   = 3'b100,
        OP_OR    = 3'b101,
        OP_XOR   = 3'b110,
        OP_SHIFT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } alu_flags_t;
endpackage

// File: rtl/alu_imm_expand.sv
module alu_imm_expand
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  alu_op_e            op,
    input  logic [IMM_W-1:0]   imm,
    input  logic               hi_sel,
    output logic [WIDTH-1:0]   opnd
);
    localparam int EXT_W = WIDTH - IMM_W;

    logic [WIDTH-1:0] fill;

    always_comb begin
        fill = (op == OP_AND) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
        if (op == OP_SHIFT) begin
            opnd = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else if (hi_sel) begin
            opnd = fill;
            opnd[WIDTH-1 -: IMM_W] = imm;
        end else begin
            opnd = fill;
            opnd[IMM_W-1:0] = imm;
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] amount,
    input  logic             arith,
    output logic [WIDTH-1:0] shifted,
    output logic             carry
);
    localparam int SH_W = $clog2(WIDTH);

    logic             go_right;
    logic [WIDTH-1:0] mag;
    logic             out_of_range;
    logic [WIDTH:0]   left_ext;
    logic [WIDTH-1:0] right_val;

    always_comb begin
        go_right     = amount[WIDTH-1];
        mag          = go_right ? (~amount + 1'b1) : amount;
        out_of_range = |mag[WIDTH-1:SH_W];
        left_ext     = {1'b0, data} << mag[SH_W-1:0];
        right_val    = arith ? WIDTH'($signed(data) >>> mag[SH_W-1:0])
                             : (data >> mag[SH_W-1:0]);
        if (!go_right) begin
            shifted = out_of_range ? '0 : left_ext[WIDTH-1:0];
            carry   = out_of_range ? 1'b0 : left_ext[WIDTH];
        end else begin
            if (out_of_range)
                shifted = arith ? {WIDTH{data[WIDTH-1]}} : '0;
            else
                shifted = right_val;
            carry = 1'b0;
        end
    end

    // R10: a right shift never produces a carry
    always_comb begin
        if (amount[WIDTH-1])
            assert_right_no_carry_R10: assert (carry == 1'b0 || $isunknown(amount));
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_flag,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    logic [WIDTH-1:0] addend;
    logic             cin;

    always_comb begin
        unique case (op)
            OP_ADDC: begin addend = b;  cin = carry_flag; end
            OP_SUB:  begin addend = ~b; cin = 1'b1;       end
            OP_SUBB: begin addend = ~b; cin = carry_flag; end
            default: begin addend = b;  cin = 1'b0;       end
        endcase
        {cout, sum} = {1'b0, a} + {1'b0, addend} + {{WIDTH{1'b0}}, cin};
        ovf = (a[WIDTH-1] == addend[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  alu_flags_t nxt,
    output alu_flags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= nxt;
    end

    // R11: flags keep their value when the write enable is low
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/flagged_shift_alu.sv
module flagged_shift_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [31:0]      src_a_i,
    input  logic [31:0]      src_b_i,
    input  logic [15:0]      imm_i,
    input  logic             imm_sel_i,
    input  logic             alt_i,
    input  logic             flag_we_i,
    output logic [31:0]      result_o,
    output logic             z_o,
    output logic             n_o,
    output logic             v_o,
    output logic             c_o
);
    alu_op_e          op;
    logic [WIDTH-1:0] imm_opnd;
    logic [WIDTH-1:0] opnd_b;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic [WIDTH-1:0] sh_res;
    logic             sh_carry;
    logic [WIDTH-1:0] res;
    alu_flags_t       flags_q;
    alu_flags_t       flags_d;

    assign op     = alu_op_e'(op_i);
    assign opnd_b = imm_sel_i ? imm_opnd : src_b_i;

    alu_imm_expand #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_imm (
        .op     (op),
        .imm    (imm_i),
        .hi_sel (alt_i),
        .opnd   (imm_opnd)
    );

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .op         (op),
        .a          (src_a_i),
        .b          (opnd_b),
        .carry_flag (flags_q.c),
        .sum        (add_sum),
        .cout       (add_cout),
        .ovf        (add_ovf)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shift (
        .data    (src_a_i),
        .amount  (opnd_b),
        .arith   (alt_i),
        .shifted (sh_res),
        .carry   (sh_carry)
    );

    always_comb begin
        flags_d = '0;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
                res       = add_sum;
                flags_d.v = add_ovf;
                flags_d.c = add_cout;
            end
            OP_AND:   res = src_a_i & opnd_b;
            OP_OR:    res = src_a_i | opnd_b;
            OP_XOR:   res = src_a_i ^ opnd_b;
            OP_SHIFT: begin
                res       = sh_res;
                flags_d.c = sh_carry;
            end
            default:  res = '0;
        endcase
        flags_d.z = (res == '0);
        flags_d.n = res[WIDTH-1];
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we_i),
        .nxt   (flags_d),
        .q     (flags_q)
    );

    assign result_o = res;
    assign z_o      = flags_q.z;
    assign n_o      = flags_q.n;
    assign v_o      = flags_q.v;
    assign c_o      = flags_q.c;

    // R8: zero flag follows the result sampled at the enabled edge
    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> (z_o == $past(result_o == '0)));

    // R8: negative flag copies the result sign
    assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> (n_o == $past(result_o[WIDTH-1])));

    // R9: logic and shift operations clear overflow
    assert_no_ovf_logic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i[2]) |=> !v_o);

    // R10: logic operations clear carry
    assert_no_carry_logic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i[2] && (op_i != 3'b111)) |=> !c_o);
endmodule

// File: tb/flagged_shift_alu_bench.sv
module flagged_shift_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [15:0] imm_i = '0;
    logic        imm_sel_i = 1'b0;
    logic        alt_i = 1'b0;
    logic        flag_we_i = 1'b0;
    logic [31:0] result_o;
    logic        z_o, n_o, v_o, c_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] exp_f = 4'b0000;   // {z,n,v,c}
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    flagged_shift_alu u_flagged_shift_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .imm_i(imm_i), .imm_sel_i(imm_sel_i),
        .alt_i(alt_i), .flag_we_i(flag_we_i), .result_o(result_o),
        .z_o(z_o), .n_o(n_o), .v_o(v_o), .c_o(c_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent model: returns {z,n,v,c,result}
    function automatic logic [35:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic cflag,
                                          input logic alt);
        logic [31:0] r = 0;
        logic v = 0, c = 0;
        logic [32:0] wide;
        longint amt;
        amt = longint'($signed(b));
        case (op)
            3'd0: wide = {1'b0, a} + {1'b0, b};
            3'd1: wide = {1'b0, a} + {1'b0, b} + {32'd0, cflag};
            3'd2: wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
            3'd3: wide = {1'b0, a} + {1'b0, ~b} + {32'd0, cflag};
            default: wide = '0;
        endcase
        if (op < 3'd4) begin
            logic [31:0] bb;
            bb = op[1] ? ~b : b;
            r = wide[31:0]; c = wide[32];
            v = (a[31] == bb[31]) && (r[31] != a[31]);
        end else if (op == 3'd4) r = a & b;
        else if (op == 3'd5) r = a | b;
        else if (op == 3'd6) r = a ^ b;
        else begin
            if (amt >= 0 && amt < 32) begin
                for (int i = 0; i < 32; i++) r[i] = (i >= amt) ? a[i - int'(amt)] : 1'b0;
                c = (amt == 0) ? 1'b0 : a[32 - int'(amt)];
            end else if (amt < 0 && amt > -32) begin
                for (int i = 0; i < 32; i++)
                    r[i] = (i - amt < 32) ? a[i - int'(amt)] : (alt ? a[31] : 1'b0);
            end else begin
                r = (amt < 0 && alt) ? {32{a[31]}} : 32'd0;
            end
        end
        return {(r == 0), r[31], v, c, r};
    endfunction

    function automatic logic [31:0] widen(input logic [2:0] op, input logic [15:0] k,
                                          input logic alt);
        logic [15:0] other;
        if (op == 3'd7) return {{16{k[15]}}, k};
        other = (op == 3'd4) ? 16'hFFFF : 16'h0000;
        return alt ? {k, other} : {other, k};
    endfunction

    // One vector: drive at negedge, check result, then flags after the edge
    task automatic run_vec(input string req, input logic [2:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic use_k, input logic [15:0] k,
                           input logic alt, input logic we);
        logic [35:0] m;
        logic [31:0] bop;
        @(negedge clk);
        op_i = op; src_a_i = a; src_b_i = b; imm_i = k;
        imm_sel_i = use_k; alt_i = alt; flag_we_i = we;
        bop = use_k ? widen(op, k, alt) : b;
        m = model(op, a, bop, exp_f[0], alt);
        #1;
        check(req, "result", result_o, m[31:0]);
        if (we) exp_f = m[35:32];
        @(posedge clk); #1;
        check(req, "flags znvc", {28'd0, z_o, n_o, v_o, c_o}, {28'd0, exp_f});
    endtask

    task automatic t_reset;
        check("R11", "reset flags", {28'd0, z_o, n_o, v_o, c_o}, 32'd0);
    endtask

    task automatic t_arith;
        run_vec("R1", 3'd0, 32'd5, 32'd7, 0, 0, 0, 1);
        run_vec("R1", 3'd0, 32'hFFFFFFFF, 32'd1, 0, 0, 0, 1);
        run_vec("R9", 3'd0, 32'h7FFFFFFF, 32'd1, 0, 0, 0, 1);
        run_vec("R1", 3'd2, 32'd5, 32'd5, 0, 0, 0, 1);
        run_vec("R10", 3'd2, 32'd3, 32'd5, 0, 0, 0, 1);
        run_vec("R9", 3'd2, 32'h80000000, 32'd1, 0, 0, 0, 1);
    endtask

    task automatic t_carry_chain;
        run_vec("R10", 3'd0, 32'hFFFFFFFF, 32'd2, 0, 0, 0, 1);   // C=1
        run_vec("R2", 3'd1, 32'd1, 32'd1, 0, 0, 0, 1);           // uses C=1 -> 3, C->0
        run_vec("R2", 3'd1, 32'd1, 32'd1, 0, 0, 0, 1);           // uses C=0 -> 2
        run_vec("R2", 3'd3, 32'd10, 32'd3, 0, 0, 0, 1);          // C=0 -> 6, C=1
        run_vec("R2", 3'd3, 32'd10, 32'd3, 0, 0, 0, 1);          // C=1 -> 7
    endtask

    task automatic t_logic;
        run_vec("R9", 3'd2, 32'h80000000, 32'd1, 0, 0, 0, 1);    // set V and C
        run_vec("R3", 3'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 0, 1);
        run_vec("R3", 3'd5, 32'hA000_0001, 32'h0500_0010, 0, 0, 0, 1);
        run_vec("R3", 3'd6, 32'h5555_AAAA, 32'h5555_AAAA, 0, 0, 0, 1);
    endtask

    task automatic t_imm;
        run_vec("R4", 3'd0, 32'h0000_0001, 32'hDEAD_BEEF, 1, 16'h1234, 0, 1);
        run_vec("R4", 3'd0, 32'h0000_0001, 32'hDEAD_BEEF, 1, 16'h1234, 1, 1);
        run_vec("R4", 3'd4, 32'h8765_4321, 32'h0, 1, 16'h00F0, 0, 1);
        run_vec("R4", 3'd4, 32'h8765_4321, 32'h0, 1, 16'h0F00, 1, 1);
        run_vec("R4", 3'd5, 32'h0000_0000, 32'hFFFF_FFFF, 1, 16'h8001, 1, 1);
    endtask

    task automatic t_shift;
        run_vec("R5", 3'd7, 32'h8000_00F0, 0, 1, 16'hFFFC, 0, 1);  // -4 logical
        run_vec("R5", 3'd7, 32'h8000_00F0, 0, 1, 16'hFFFC, 1, 1);  // -4 arithmetic
        run_vec("R10", 3'd7, 32'h1800_0001, 0, 1, 16'h0004, 0, 1); // left 4, C=1
        run_vec("R6", 3'd7, 32'hC000_0003, 32'd0, 0, 0, 0, 1);
        run_vec("R6", 3'd7, 32'h0000_0003, 32'd31, 0, 0, 0, 1);
        run_vec("R6", 3'd7, 32'h8000_0000, 32'hFFFF_FFE1, 0, 0, 1, 1); // -31 arith
        run_vec("R6", 3'd7, 32'h8000_0000, 32'hFFFF_FFE1, 0, 0, 0, 1); // -31 logic
    endtask

    task automatic t_range;
        run_vec("R7", 3'd7, 32'hFFFF_FFFF, 32'd32, 0, 0, 0, 1);
        run_vec("R7", 3'd7, 32'h9000_0000, 32'hFFFF_FFE0, 0, 0, 1, 1);  // -32 arith
        run_vec("R7", 3'd7, 32'h9000_0000, 32'hFFFF_FFE0, 0, 0, 0, 1);  // -32 logic
        run_vec("R7", 3'd7, 32'h0000_0001, 32'd100, 0, 0, 1, 1);
        run_vec("R7", 3'd7, 32'h7000_0000, 32'hFFFF_FF9C, 0, 0, 1, 1);  // -100 arith, positive
        run_vec("R7", 3'd7, 32'h8000_0001, 32'h8000_0000, 0, 0, 1, 1);  // most negative
    endtask

    task automatic t_hold;
        run_vec("R8", 3'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 1);   // Z=1, C=1
        run_vec("R11", 3'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0);  // N,V would set
        run_vec("R11", 3'd4, 32'h0, 32'h0, 0, 0, 0, 0);
        run_vec("R8", 3'd6, 32'h8000_0000, 32'h1, 0, 0, 0, 1);   // N=1
    endtask

    initial begin
        #12;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_arith();
        t_carry_chain();
        t_logic();
        t_imm();
        t_shift();
        t_range();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule